// File: doc/BRIEF.md
# Interrupt Redirection Register File

This block is the software-visible half of an interrupt routing unit. It keeps a unit identifier, an arbitration identifier, a read-only version word, and a table of routing entries, one for each interrupt input line. Software reaches all of these through two bus offsets. It writes a register number into the select register at one offset. It then reads or writes the chosen register through the data window at the other offset. Each routing entry is 64 bits wide and is split into a low half and a high half, and each half has its own register number.

The routing logic next to the block reads the fields of every entry from dedicated outputs. These fields are vector, delivery mode, destination mode, polarity, trigger mode, mask and destination. Bus requests are handled by a two-state machine. In `ST_IDLE` the block is ready and takes a request, and it moves to `ST_RESP` on `accept`. In `ST_RESP` the block drives one registered response beat with `req_ready` held low, and it goes back to `ST_IDLE` unconditionally. A write takes effect on the clock edge that accepts it.

Top module: `intr_redir_regfile`

## Requirements
- R1: After reset the select register reads 0, the unit ID and the arbitration ID both equal `UNIT_ID_RST`, every entry's low half reads 0x0001_0000 (only the mask bit set) and every high half reads 0.
- R2: Offset 0x00 is the select register. A write stores bits 7:0 of the data, and a read returns that value zero-extended.
- R3: A request is an error if its offset is neither 0x00 nor 0x10, or if its byte enables are not all ones. An error response has `rsp_err`=1 and `rsp_rdata`=0 and changes no register.
- R4: Register 0x00 holds the unit ID in bits 31:24. A write stores data bits 31:24, and bits 23:0 always read 0.
- R5: Register 0x01 reads `{8'h00, NUM_ENT-1, 8'h00, VERSION}`, which is 0x0017_0011 by default. Writes to it have no effect.
- R6: Register 0x02 holds the arbitration ID in bits 31:24, under the same rules as R4.
- R7: Entry k has its low half at register 0x10+2k and its high half at register 0x11+2k. A write keeps only the defined bits and clears the rest. The low half keeps mask 0x0001_AFFF and the high half keeps mask 0xFF00_0000.
- R8: Registers 0x03 to 0x0F, and registers from 0x10+2·NUM_ENT upward, read 0 without an error. Writes to them change nothing.
- R9: `req_ready` is 1 in `ST_IDLE`. An accepted request produces `rsp_valid`=1 in exactly the next cycle, for one cycle only, and `req_ready` is 0 in that cycle.
- R10: The field outputs of entry k show its stored halves in these bit positions: vector from low bits 7:0, delivery mode from low bits 10:8, logical destination from low bit 11, active-low from low bit 13, level trigger from low bit 15, mask from low bit 16, and destination from high bits 31:24. Each output updates in the cycle after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset within the block |
| req_be | input | 4 | Byte enables; all four must be set |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response beat |
| rsp_rdata | output | 32 | Read data (0 for writes and errors) |
| rsp_err | output | 1 | Illegal offset or partial access |
| ent_vector | output | NUM_ENT*8 | Per-entry vector |
| ent_dlv_mode | output | NUM_ENT*3 | Per-entry delivery mode |
| ent_dst_logical | output | NUM_ENT | Per-entry destination mode |
| ent_active_low | output | NUM_ENT | Per-entry polarity |
| ent_level | output | NUM_ENT | Per-entry trigger mode |
| ent_masked | output | NUM_ENT | Per-entry mask |
| ent_dest | output | NUM_ENT*8 | Per-entry destination |

## Verification
The handshake assertions assume that the requester holds `req_valid` only while `req_ready` is high. They also assume it never expects a second beat in `ST_RESP`. The bench drives each request for exactly one cycle in `ST_IDLE` and then waits out the response cycle, so it stays within these limits. The stability assertions assume that a register changes only when the decoder flags a legal write to it. The bench tests this by sending illegal offsets and partial byte enables and then reading back the contents that are exposed.

// File: rtl/iorr_pkg.sv
package iorr_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } bus_st_t;

    localparam logic [7:0]  OFF_SEL  = 8'h00;
    localparam logic [7:0]  OFF_DAT  = 8'h10;

    localparam logic [7:0]  IDX_ID   = 8'h00;
    localparam logic [7:0]  IDX_VER  = 8'h01;
    localparam logic [7:0]  IDX_ARB  = 8'h02;
    localparam int          IDX_TBL  = 16;

    localparam logic [31:0] LO_KEEP  = 32'h0001_AFFF;
    localparam logic [31:0] HI_KEEP  = 32'hFF00_0000;
    localparam logic [31:0] LO_RESET = 32'h0001_0000;
    localparam logic [31:0] HI_RESET = 32'h0000_0000;

    typedef struct packed {
        logic [7:0] dest;
        logic       masked;
        logic       level;
        logic       active_low;
        logic       dst_logical;
        logic [2:0] dlv_mode;
        logic [7:0] vector;
    } ent_fields_t;

    function automatic ent_fields_t split_entry(input logic [31:0] lo, input logic [31:0] hi);
        ent_fields_t f;
        f.vector      = lo[7:0];
        f.dlv_mode    = lo[10:8];
        f.dst_logical = lo[11];
        f.active_low  = lo[13];
        f.level       = lo[15];
        f.masked      = lo[16];
        f.dest        = hi[31:24];
        return f;
    endfunction

endpackage

// File: rtl/iorr_bus_fsm.sv
module iorr_bus_fsm
    import iorr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic [31:0] rd_word,
    input  logic        rd_err,
    output logic        req_ready,
    output logic        accept,
    output logic        rsp_valid,
    output logic [31:0] rsp_rdata,
    output logic        rsp_err
);

    bus_st_t st_q, st_d;

    assign req_ready = (st_q == ST_IDLE);
    assign accept    = req_ready && req_valid;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (req_valid) st_d = ST_RESP;
            ST_RESP: st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= 32'h0;
            rsp_err   <= 1'b0;
        end else if (accept) begin
            rsp_valid <= 1'b1;
            rsp_rdata <= rd_word;
            rsp_err   <= rd_err;
        end else begin
            rsp_valid <= 1'b0;
            rsp_rdata <= 32'h0;
            rsp_err   <= 1'b0;
        end
    end

    p_rsp_follows_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid);

    p_rsp_single_beat_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_no_accept_during_rsp_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

endmodule

// File: rtl/iorr_window.sv
module iorr_window
    import iorr_pkg::*;
#(
    parameter int          NUM_ENT     = 24,
    parameter int          ADDR_W      = 8,
    parameter logic [7:0]  VERSION     = 8'h11,
    parameter logic [7:0]  UNIT_ID_RST = 8'h02,
    localparam int         EIDX_W      = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [3:0]        req_be,
    input  logic [31:0]       req_wdata,
    input  logic [31:0]       ent_lo [NUM_ENT],
    input  logic [31:0]       ent_hi [NUM_ENT],
    output logic [NUM_ENT-1:0] wr_lo,
    output logic [NUM_ENT-1:0] wr_hi,
    output logic [31:0]       rd_word,
    output logic              rd_err
);

    localparam int          TBL_END  = IDX_TBL + 2 * NUM_ENT;
    localparam logic [31:0] VER_WORD = {8'h00, 8'(NUM_ENT - 1), 8'h00, VERSION};

    logic [7:0]        sel_q;
    logic [7:0]        id_q;
    logic [7:0]        arb_q;
    logic              hit_sel, hit_dat, full_word, legal;
    logic              in_tbl, do_wr, tbl_wr;
    logic [7:0]        tbl_off;
    logic [EIDX_W-1:0] ent_idx;
    logic [31:0]       reg_word;

    assign hit_sel   = (req_addr == ADDR_W'(OFF_SEL));
    assign hit_dat   = (req_addr == ADDR_W'(OFF_DAT));
    assign full_word = &req_be;
    assign legal     = (hit_sel || hit_dat) && full_word;

    assign in_tbl  = (int'(sel_q) >= IDX_TBL) && (int'(sel_q) < TBL_END);
    assign tbl_off = sel_q - 8'(IDX_TBL);
    assign ent_idx = EIDX_W'(tbl_off >> 1);

    assign do_wr  = accept && req_write && legal && hit_dat;
    assign tbl_wr = do_wr && in_tbl;

    for (genvar k = 0; k < NUM_ENT; k++) begin : g_we
        assign wr_lo[k] = tbl_wr && (ent_idx == EIDX_W'(k)) && !sel_q[0];
        assign wr_hi[k] = tbl_wr && (ent_idx == EIDX_W'(k)) &&  sel_q[0];
    end

    always_comb begin
        reg_word = 32'h0;
        if (in_tbl) begin
            reg_word = sel_q[0] ? ent_hi[ent_idx] : ent_lo[ent_idx];
        end else begin
            unique case (sel_q)
                IDX_ID:  reg_word = {id_q, 24'h0};
                IDX_VER: reg_word = VER_WORD;
                IDX_ARB: reg_word = {arb_q, 24'h0};
                default: reg_word = 32'h0;
            endcase
        end
    end

    always_comb begin
        rd_err  = !legal;
        rd_word = 32'h0;
        if (legal && !req_write) rd_word = hit_sel ? {24'h0, sel_q} : reg_word;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= 8'h00;
            id_q  <= UNIT_ID_RST;
            arb_q <= UNIT_ID_RST;
        end else begin
            if (accept && req_write && legal && hit_sel) sel_q <= req_wdata[7:0];
            if (do_wr && sel_q == IDX_ID)  id_q  <= req_wdata[31:24];
            if (do_wr && sel_q == IDX_ARB) arb_q <= req_wdata[31:24];
        end
    end

    p_illegal_keeps_regs_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !legal) |=> ($stable(sel_q) && $stable(id_q) && $stable(arb_q)));

    p_one_half_written_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({wr_lo, wr_hi}) <= 1);

    p_no_tbl_write_outside_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_tbl |-> ({wr_lo, wr_hi} == '0));

endmodule

// File: rtl/iorr_entry_bank.sv
module iorr_entry_bank
    import iorr_pkg::*;
#(
    parameter int NUM_ENT = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_ENT-1:0] wr_lo,
    input  logic [NUM_ENT-1:0] wr_hi,
    input  logic [31:0]        wdata,
    output logic [31:0]        ent_lo [NUM_ENT],
    output logic [31:0]        ent_hi [NUM_ENT]
);

    for (genvar k = 0; k < NUM_ENT; k++) begin : g_ent
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_lo[k] <= LO_RESET;
                ent_hi[k] <= HI_RESET;
            end else begin
                if (wr_lo[k]) ent_lo[k] <= wdata & LO_KEEP;
                if (wr_hi[k]) ent_hi[k] <= wdata & HI_KEEP;
            end
        end

        p_lo_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_lo[k] |=> $stable(ent_lo[k]));

        p_hi_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_hi[k] |=> $stable(ent_hi[k]));
    end

endmodule

// File: rtl/intr_redir_regfile.sv
module intr_redir_regfile
    import iorr_pkg::*;
#(
    parameter int         NUM_ENT     = 24,
    parameter int         ADDR_W      = 8,
    parameter logic [7:0] VERSION     = 8'h11,
    parameter logic [7:0] UNIT_ID_RST = 8'h02
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic                  req_write,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [3:0]            req_be,
    input  logic [31:0]           req_wdata,
    output logic                  rsp_valid,
    output logic [31:0]           rsp_rdata,
    output logic                  rsp_err,
    output logic [NUM_ENT*8-1:0]  ent_vector,
    output logic [NUM_ENT*3-1:0]  ent_dlv_mode,
    output logic [NUM_ENT-1:0]    ent_dst_logical,
    output logic [NUM_ENT-1:0]    ent_active_low,
    output logic [NUM_ENT-1:0]    ent_level,
    output logic [NUM_ENT-1:0]    ent_masked,
    output logic [NUM_ENT*8-1:0]  ent_dest
);

    logic               accept;
    logic [31:0]        rd_word;
    logic               rd_err;
    logic [NUM_ENT-1:0] wr_lo, wr_hi;
    logic [31:0]        ent_lo [NUM_ENT];
    logic [31:0]        ent_hi [NUM_ENT];

    iorr_bus_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .rd_word   (rd_word),
        .rd_err    (rd_err),
        .req_ready (req_ready),
        .accept    (accept),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .rsp_err   (rsp_err)
    );

    iorr_window #(
        .NUM_ENT     (NUM_ENT),
        .ADDR_W      (ADDR_W),
        .VERSION     (VERSION),
        .UNIT_ID_RST (UNIT_ID_RST)
    ) u_win (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_be    (req_be),
        .req_wdata (req_wdata),
        .ent_lo    (ent_lo),
        .ent_hi    (ent_hi),
        .wr_lo     (wr_lo),
        .wr_hi     (wr_hi),
        .rd_word   (rd_word),
        .rd_err    (rd_err)
    );

    iorr_entry_bank #(
        .NUM_ENT (NUM_ENT)
    ) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_lo  (wr_lo),
        .wr_hi  (wr_hi),
        .wdata  (req_wdata),
        .ent_lo (ent_lo),
        .ent_hi (ent_hi)
    );

    for (genvar k = 0; k < NUM_ENT; k++) begin : g_fields
        ent_fields_t f;
        assign f = split_entry(ent_lo[k], ent_hi[k]);
        assign ent_vector[k*8 +: 8]   = f.vector;
        assign ent_dlv_mode[k*3 +: 3] = f.dlv_mode;
        assign ent_dst_logical[k]     = f.dst_logical;
        assign ent_active_low[k]      = f.active_low;
        assign ent_level[k]           = f.level;
        assign ent_masked[k]          = f.masked;
        assign ent_dest[k*8 +: 8]     = f.dest;
    end

    p_err_read_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> (rsp_rdata == 32'h0));

endmodule

// File: tb/sim_intr_redir_regfile.sv
`timescale 1ns/1ps
module sim_intr_redir_regfile;

    localparam int N = 24;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic            req_ready;
    logic            req_write = 1'b0;
    logic [7:0]      req_addr = 8'h0;
    logic [3:0]      req_be = 4'hF;
    logic [31:0]     req_wdata = 32'h0;
    logic            rsp_valid;
    logic [31:0]     rsp_rdata;
    logic            rsp_err;
    logic [N*8-1:0]  ent_vector, ent_dest;
    logic [N*3-1:0]  ent_dlv_mode;
    logic [N-1:0]    ent_dst_logical, ent_active_low, ent_level, ent_masked;

    intr_redir_regfile #(.NUM_ENT(N)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_be(req_be),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .rsp_err(rsp_err), .ent_vector(ent_vector), .ent_dlv_mode(ent_dlv_mode),
        .ent_dst_logical(ent_dst_logical), .ent_active_low(ent_active_low),
        .ent_level(ent_level), .ent_masked(ent_masked), .ent_dest(ent_dest)
    );

    always #5 clk = ~clk;

    int total = 0;
    int bad = 0;

    logic [7:0]  m_id, m_arb, m_sel;
    logic [31:0] m_lo [N];
    logic [31:0] m_hi [N];

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_rd(input int idx);
        if (idx == 0) return {m_id, 24'h0};
        if (idx == 1) return 32'h0017_0011;
        if (idx == 2) return {m_arb, 24'h0};
        if (idx >= 16 && idx < 16 + 2*N)
            return (idx % 2) ? m_hi[(idx-16)/2] : m_lo[(idx-16)/2];
        return 32'h0;
    endfunction

    function automatic string tag_of(input int idx);
        if (idx == 0) return "R4";
        if (idx == 1) return "R5";
        if (idx == 2) return "R6";
        if (idx >= 16 && idx < 16 + 2*N) return "R7";
        return "R8";
    endfunction

    task automatic model_wr(input int idx, input logic [31:0] v);
        if (idx == 0) m_id = v[31:24];
        else if (idx == 2) m_arb = v[31:24];
        else if (idx >= 16 && idx < 16 + 2*N) begin
            if (idx % 2) m_hi[(idx-16)/2] = v & 32'hFF00_0000;
            else         m_lo[(idx-16)/2] = v & 32'h0001_AFFF;
        end
    endtask

    task automatic access(input bit wr, input logic [7:0] addr, input logic [3:0] be,
                          input logic [31:0] wd, output logic [31:0] rd, output logic er);
        @(negedge clk);
        chk(req_ready === 1'b1 && rsp_valid === 1'b0, "R9 idle", {30'h0, req_ready, rsp_valid}, 32'h2);
        req_valid = 1'b1; req_write = wr; req_addr = addr; req_be = be; req_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(rsp_valid === 1'b1 && req_ready === 1'b0, "R9 resp", {30'h0, req_ready, rsp_valid}, 32'h1);
        rd = rsp_rdata;
        er = rsp_err;
    endtask

    task automatic set_sel(input int idx);
        logic [31:0] r; logic e;
        access(1'b1, 8'h00, 4'hF, 32'h0000_0000 | idx, r, e);
        m_sel = 8'(idx);
    endtask

    task automatic rd_check(input int idx, input string tag);
        logic [31:0] r; logic e;
        set_sel(idx);
        access(1'b0, 8'h10, 4'hF, 32'h0, r, e);
        chk(r === exp_rd(idx) && e === 1'b0, tag, r, exp_rd(idx));
    endtask

    task automatic wr_idx(input int idx, input logic [31:0] v);
        logic [31:0] r; logic e;
        set_sel(idx);
        access(1'b1, 8'h10, 4'hF, v, r, e);
        chk(e === 1'b0 && r === 32'h0, "R7 write resp", r, 32'h0);
        model_wr(idx, v);
    endtask

    task automatic check_fields(input string tag);
        for (int k = 0; k < N; k++) begin
            logic [63:0] a, x;
            a = {ent_dest[k*8 +: 8], ent_masked[k], ent_level[k], ent_active_low[k],
                 ent_dst_logical[k], ent_dlv_mode[k*3 +: 3], ent_vector[k*8 +: 8], 32'h0};
            x = {m_hi[k][31:24], m_lo[k][16], m_lo[k][15], m_lo[k][13], m_lo[k][11],
                 m_lo[k][10:8], m_lo[k][7:0], 32'h0};
            chk(a === x, tag, a[63:32], x[63:32]);
        end
    endtask

    initial begin
        #1_000_000;
        total++; bad++;
        $display("FAIL watchdog actual=%08h expected=%08h", 32'h0, 32'h1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] r;
        logic        e;
        m_id = 8'h02; m_arb = 8'h02; m_sel = 8'h00;
        for (int k = 0; k < N; k++) begin m_lo[k] = 32'h0001_0000; m_hi[k] = 32'h0; end

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rsp_valid === 1'b0, "R1 rsp idle", {31'h0, rsp_valid}, 32'h0);
        chk(ent_masked === {N{1'b1}}, "R1 masks", 32'(ent_masked), 32'(ent_masked | ~ent_masked));
        check_fields("R1 fields");

        // R2 select reads 0 after reset
        access(1'b0, 8'h00, 4'hF, 32'h0, r, e);
        chk(r === 32'h0 && e === 1'b0, "R1 sel reset", r, 32'h0);

        // R1 sweep of reset contents over all defined and some undefined indices
        for (int i = 0; i < 16 + 2*N + 8; i++) rd_check(i, i < 16 + 2*N ? "R1 reset" : "R8 reset");
        rd_check(255, "R8 top");

        // R2 select readback with upper data bits set
        access(1'b1, 8'h00, 4'hF, 32'hABCD_EF5A, r, e);
        access(1'b0, 8'h00, 4'hF, 32'h0, r, e);
        chk(r === 32'h0000_005A, "R2 sel readback", r, 32'h5A);

        // pass 1: all ones everywhere, pass 2: arithmetic pattern
        for (int pass = 0; pass < 2; pass++) begin
            for (int i = 0; i < 16 + 2*N + 8; i++)
                wr_idx(i, pass == 0 ? 32'hFFFF_FFFF : (32'hDEAD_BEEF ^ (i * 32'h0101_0101)));
            for (int i = 0; i < 16 + 2*N + 8; i++) rd_check(i, tag_of(i));
            check_fields("R10 fields");
        end

        // R5 version ignores writes
        wr_idx(1, 32'h1234_5678);
        rd_check(1, "R5 after write");

        // R10 single entry update visible right after accept
        wr_idx(16 + 2*5, 32'h0000_A7C4);
        chk(ent_vector[5*8 +: 8] === 8'hC4 && ent_dlv_mode[5*3 +: 3] === 3'd7 && ent_masked[5] === 1'b0
            && ent_level[5] === 1'b1 && ent_active_low[5] === 1'b1 && ent_dst_logical[5] === 1'b0,
            "R10 entry5", {ent_vector[5*8 +: 8], 5'h0, ent_dlv_mode[5*3 +: 3], 16'h0},
            {8'hC4, 5'h0, 3'd7, 16'h0});
        wr_idx(16 + 2*5 + 1, 32'h9B00_0000);
        chk(ent_dest[5*8 +: 8] === 8'h9B, "R10 dest5", 32'(ent_dest[5*8 +: 8]), 32'h9B);

        // R3 illegal offsets and partial accesses
        set_sel(16);
        for (int off = 1; off < 256; off += 7) begin
            if (off == 16) continue;
            access(1'b1, 8'(off), 4'hF, 32'h0000_0003, r, e);
            chk(e === 1'b1 && r === 32'h0, "R3 bad offset", {r[30:0], e}, 32'h1);
        end
        access(1'b1, 8'h00, 4'h7, 32'h0000_0002, r, e);
        chk(e === 1'b1 && r === 32'h0, "R3 partial sel", {r[30:0], e}, 32'h1);
        access(1'b1, 8'h10, 4'hE, 32'h0000_00FF, r, e);
        chk(e === 1'b1, "R3 partial data", {31'h0, e}, 32'h1);
        access(1'b0, 8'h10, 4'h1, 32'h0, r, e);
        chk(e === 1'b1 && r === 32'h0, "R3 partial read", r, 32'h0);
        access(1'b0, 8'h00, 4'hF, 32'h0, r, e);
        chk(r === 32'h10, "R3 sel unchanged", r, 32'h10);
        access(1'b0, 8'h10, 4'hF, 32'h0, r, e);
        chk(r === m_lo[0], "R3 entry unchanged", r, m_lo[0]);
        check_fields("R3 fields unchanged");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule